// File: doc/BRIEF.md
# Two-Stage SPI Bit-Clock Divider

This block produces the serial bit clock of an SPI master from the system clock. A configuration word carries two fields. The first is a 5-bit prescaler that scales the ratio by 1 to 32. The second is a 3-bit code that either multiplies the ratio by a power of two from 2 to 32 or bypasses that stage. The product N is the number of system-clock cycles in each SCK half-period. The block drives SCK and, in the cycle where each new SCK level first appears, a one-cycle strobe. A shift engine uses that strobe to launch and sample data.

An enable input starts and stops SCK. While SCK is stopped it rests at an idle level chosen by a polarity input. The configuration word and the polarity are captured only while SCK is stopped. A stop request never cuts a half-period short at the active level, so no runt pulse reaches the bus.

Top module: `sckDivTop`

## Requirements
- R1: The prescale field sits in cfgWord bits 12:8 and holds the prescale value minus one. The half-period N is (field + 1) times the second-stage factor, so with the bypass code the field alone gives N from 1 to 32.
- R2: The divider code sits in cfgWord bits 2:0. Codes 0, 1, 2, 3 and 4 set the second-stage factor to 2, 4, 8, 16 and 32. With prescale 32 and code 4, N is 1024.
- R3: Code 7 bypasses the second stage, so N equals the prescale value.
- R4: The reserved codes 5 and 6 behave exactly like code 7.
- R5: Let E0 be the clock edge that first samples sckEnable high. SCK first changes level at the N-th edge after E0 and then changes every N edges. With N = 1, SCK changes at every edge.
- R6: edgeStb is high for exactly one cycle for each SCK level change, in the cycle where the new level first appears, and is low at all other times.
- R7: While stopped, sckOut equals idlePolarity one cycle after it is applied and edgeStb is low. After reset, sckOut is 0.
- R8: If sckEnable is sampled low while SCK is at its idle level, SCK stops with no further change. If it is sampled low while SCK is at its active level, the current half-period completes, SCK returns to idle with one strobe, and then it stops.
- R9: While SCK runs, changes to cfgWord and idlePolarity have no effect. The values present at edge E0 govern the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckEnable | input | 1 | Run request for SCK |
| idlePolarity | input | 1 | SCK level while stopped |
| cfgWord | input | 16 | Prescale field in bits 12:8, divider code in bits 2:0 |
| sckOut | output | 1 | Serial bit clock |
| edgeStb | output | 1 | One-cycle strobe marking each SCK level change |

## Verification
The hardest case to reach from the ports is a stop request that arrives while SCK is at its active level partway through a half-period. It must then run out the remaining count before returning to idle. The stimulus places the deassertion at a random offset inside a random half-period, so both stop paths and many residual counts are covered. During the run it also scrambles the configuration word and the polarity, then restores them before stopping, to show that the frozen copy governs the run.

// File: rtl/sckDivPkg.sv
package sckDivPkg;
  // Commands from the control sequencer to the counter datapath
  typedef struct packed {
    logic loadCfg;  // capture configuration and polarity
    logic cntClr;   // return the half-period counter to zero
    logic cntInc;   // advance the half-period counter
  } divCmd_t;
endpackage

// File: rtl/sckDivPath.sv
module sckDivPath
  import sckDivPkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int PRE_LSB   = 8,
  parameter int PRE_W     = 5,
  parameter int CODE_LSB  = 0,
  parameter int CODE_W    = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCmd_t          cmd,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             idlePolarity,
  output logic             atTerm,
  output logic             idleLvl
);
  localparam int CNT_W = PRE_W + MAX_SHIFT;
  localparam int SH_W  = $clog2(MAX_SHIFT + 2);
  localparam logic [CFG_W-1:0] FIELD_MASK =
    CFG_W'(((1 << PRE_W) - 1) << PRE_LSB) | CFG_W'(((1 << CODE_W) - 1) << CODE_LSB);

  logic [PRE_W-1:0]  preQ;
  logic [CODE_W-1:0] codeQ;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lowMask;
  logic [SH_W-1:0]   shiftAmt;
  logic [CNT_W-1:0]  termVal;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^(cfgWord & ~FIELD_MASK);

  // Frozen copy of the fields and the idle level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ    <= '0;
      codeQ   <= '0;
      idleLvl <= 1'b0;
    end else if (cmd.loadCfg) begin
      preQ    <= cfgWord[PRE_LSB +: PRE_W];
      codeQ   <= cfgWord[CODE_LSB +: CODE_W];
      idleLvl <= idlePolarity;
    end
  end

  // Codes below MAX_SHIFT select a 2^(code+1) stage; every other code bypasses it
  always_comb begin
    lowMask  = '0;
    shiftAmt = '0;
    for (int i = 0; i < MAX_SHIFT; i++) begin
      if (codeQ == CODE_W'(i)) begin
        lowMask  = CNT_W'((1 << (i + 1)) - 1);
        shiftAmt = SH_W'(i + 1);
      end
    end
  end

  // (pre+1)*2^s - 1 == (pre << s) | (2^s - 1)
  assign termVal = (CNT_W'(preQ) << shiftAmt) | lowMask;
  assign atTerm  = (cnt == termVal);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.cntClr) cnt <= '0;
    else if (cmd.cntInc)     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sckDivCtrl.sv
module sckDivCtrl
  import sckDivPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sckEnable,
  input  logic    atTerm,
  output divCmd_t cmd,
  output logic    running,
  output logic    sckPhase,
  output logic    edgeStb
);
  logic stopNow;
  logic tick;

  // Stop only from the idle phase; an active half-period always completes
  assign stopNow = running && !sckEnable && !sckPhase;
  assign tick    = running && !stopNow && atTerm;

  always_comb begin
    cmd.loadCfg = !running;
    cmd.cntClr  = !running || tick || stopNow;
    cmd.cntInc  = !cmd.cntClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      sckPhase <= 1'b0;
      edgeStb  <= 1'b0;
    end else begin
      running  <= running ? !stopNow : sckEnable;
      sckPhase <= sckPhase ^ tick;
      edgeStb  <= tick;
    end
  end
endmodule

// File: rtl/sckDivTop.sv
module sckDivTop
  import sckDivPkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int PRE_LSB   = 8,
  parameter int PRE_W     = 5,
  parameter int CODE_LSB  = 0,
  parameter int CODE_W    = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckEnable,
  input  logic             idlePolarity,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             sckOut,
  output logic             edgeStb
);
  divCmd_t cmd;
  logic    atTerm;
  logic    idleLvl;
  logic    running;
  logic    sckPhase;

  sckDivCtrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .sckEnable (sckEnable),
    .atTerm    (atTerm),
    .cmd       (cmd),
    .running   (running),
    .sckPhase  (sckPhase),
    .edgeStb   (edgeStb)
  );

  sckDivPath #(
    .CFG_W     (CFG_W),
    .PRE_LSB   (PRE_LSB),
    .PRE_W     (PRE_W),
    .CODE_LSB  (CODE_LSB),
    .CODE_W    (CODE_W),
    .MAX_SHIFT (MAX_SHIFT)
  ) pathI (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .cfgWord      (cfgWord),
    .idlePolarity (idlePolarity),
    .atTerm       (atTerm),
    .idleLvl      (idleLvl)
  );

  assign sckOut = sckPhase ^ idleLvl;
endmodule

// File: rtl/sckDivChk.sv
module sckDivChk (
  input logic clk,
  input logic rstN,
  input logic running,
  input logic sckPhase,
  input logic idleLvl,
  input logic sckOut,
  input logic edgeStb
);
  // R6
  edge_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeStb |-> (sckOut != $past(sckOut)));

  // R8
  stb_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeStb |-> $past(running));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (sckOut == idleLvl));

  // R9
  pol_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> $stable(idleLvl));

  // R5
  start_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> (!edgeStb && !sckPhase));
endmodule

bind sckDivTop sckDivChk chkI (
  .clk      (clk),
  .rstN     (rstN),
  .running  (running),
  .sckPhase (sckPhase),
  .idleLvl  (idleLvl),
  .sckOut   (sckOut),
  .edgeStb  (edgeStb)
);

// File: tb/tb_sckDivTop.sv
module tb_sckDivTop;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sckEnable;
  logic        idlePolarity;
  logic [15:0] cfgWord;
  logic        sckOut;
  logic        edgeStb;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sckDivTop dut (
    .clk          (clk),
    .rstN         (rstN),
    .sckEnable    (sckEnable),
    .idlePolarity (idlePolarity),
    .cfgWord      (cfgWord),
    .sckOut       (sckOut),
    .edgeStb      (edgeStb)
  );

  // Half-period in system cycles, from R1 to R4
  function automatic int ratioOf(input logic [15:0] cfg);
    int pre;
    pre = int'(cfg[12:8]) + 1;
    if (cfg[2:0] <= 3'd4) return pre * (2 << cfg[2:0]);
    return pre;
  endfunction

  task automatic check(input logic expSck, input logic expStb, input string req);
    testsRun++;
    if (sckOut !== expSck || edgeStb !== expStb) begin
      testsFailed++;
      $display("FAIL %s: sck=%b stb=%b expected sck=%b stb=%b at %0t",
               req, sckOut, edgeStb, expSck, expStb, $time);
    end
  endtask

  // Run one configuration: start, optional scramble, stop after M sampled edges
  task automatic runCase(input logic [15:0] cfg, input logic pol,
                         input int stopK, input int stopR, input string req);
    int n, bigM, ph, tEdge;
    logic expPh;
    n = ratioOf(cfg);
    @(negedge clk);
    cfgWord = cfg; idlePolarity = pol; sckEnable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pol, 1'b0, "R7 idle");
    bigM = n * stopK + stopR;
    sckEnable = 1'b1;
    for (int m = 0; m <= bigM; m++) begin
      @(negedge clk);
      expPh = 1'(((m / n) % 2) != 0);
      check(expPh ^ pol, (m >= n) && (m % n == 0), req);
      if (m == bigM) begin
        cfgWord = cfg; idlePolarity = pol; sckEnable = 1'b0;
      end else if (m == 1) begin
        // R9: scramble inputs mid-run
        cfgWord = 16'($urandom); idlePolarity = ~pol;
      end
    end
    ph = (bigM / n) % 2;
    tEdge = (ph != 0) ? ((bigM / n) + 1) * n : -1;
    for (int m = bigM + 1; m <= bigM + 2 * n + 3; m++) begin
      @(negedge clk);
      check(((ph != 0) && m < tEdge) ? ~pol : pol, m == tEdge, "R8 stop");
    end
  endtask

  initial begin
    int cnt;
    cnt = 0;
    while (!finished && cnt < WATCHDOG) begin
      @(posedge clk);
      cnt++;
    end
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: expired expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; sckEnable = 1'b0; idlePolarity = 1'b0; cfgWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, "R7 reset");

    // R7: idle level follows polarity one cycle later
    idlePolarity = 1'b1;
    @(negedge clk);
    check(1'b1, 1'b0, "R7 follow");
    idlePolarity = 1'b0;
    @(negedge clk);
    check(1'b0, 1'b0, "R7 follow");

    // Directed corners
    runCase(16'h0007, 1'b0, 4, 0, "R3 R5 ratio1");
    runCase(16'h0007, 1'b1, 3, 0, "R3 R5 ratio1");
    runCase(16'h1F07, 1'b0, 1, 5, "R1 R3 pre32");
    runCase(16'h0000, 1'b1, 2, 1, "R2 R6 div2");
    runCase(16'h0205, 1'b0, 2, 2, "R4 code5");
    runCase(16'h0206, 1'b1, 1, 1, "R4 code6");
    runCase(16'h0304, 1'b0, 1, 3, "R2 div32");
    runCase(16'h1F04, 1'b1, 1, 17, "R2 max1024");
    runCase(16'h0103, 1'b0, 2, 0, "R8 idle stop");
    runCase(16'h0103, 1'b0, 1, 7, "R8 active stop");

    // Constrained random
    for (int i = 0; i < 30; i++) begin
      logic [15:0] cfg;
      int n;
      cfg = 16'($urandom);
      cfg[12] = 1'b0;
      n = ratioOf(cfg);
      runCase(cfg, 1'($urandom), 1 + int'($urandom % 3), int'($urandom % n),
              "R1 R2 R5 R6 R8 R9 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule